// File: doc/BRIEF.md
# Dual-Accumulator Operate Unit

This block is the register and operate datapath of a 12-bit accumulator machine. It holds two main accumulators (J and K), two sub-accumulators (R and S) and an overflow bit, and it executes the register-only operate words of one instruction group. Those words cover sums and differences, negated sums and differences, bitwise AND, left shift with zero fill, left rotate, and loads and exchanges between the main and sub registers. Two select bits in each word choose whether J, K or both are written.

A sequencer presents a 12-bit word on `instr_i` and raises `exec_i` for one cycle. The registers take their new values on that clock edge, and `done_o` is high for the following cycle. Memory operands, multiply and divide are handled elsewhere. Values fetched from memory reach J and K through a narrow parallel load port, and R and S are then filled by exchange operations.

Top module: `acc_op_unit`

## Requirements
- R1: While `rst_ni` is low, J, K, R, S and the overflow bit are zero and `done_o` is low.
- R2: `done_o` is high for exactly the cycle after each cycle in which `exec_i` is high. This holds for unsupported words too. When `exec_i` and `load_en_i` are both low, no register and no overflow bit changes.
- R3: Only the sum and difference words (low six bits octal 20–25 and 30–35, when accepted) write the overflow bit. It is set exactly when the true signed result lies outside the range -2^(W-1) to 2^(W-1)-1. Every other word leaves it unchanged.
- R4: Select bits: bit 7 picks K and bit 6 picks J, and both bits set picks both. Low-six codes 20–25 produce J+K, J−K, R+D, R−D, S+D and S−D, in that order, where D is the single destination register. With both destinations, only 20 and 21 are accepted, and the one result goes to J and to K.
- R5: Codes 30–35 store the two's-complement negation of the matching 20–25 result. The overflow bit is judged on the negated value, so negating −2^(W-1) sets it.
- R6: Low-six code 00 stores J AND K into the selected register or registers.
- R7: Codes 40–57 shift the selected register left by N (bits 3:0) with zero fill. When both registers are selected they act as one 2W-bit value with J in the upper half. Counts of W or more clear a single register.
- R8: Codes 60–77 rotate left by N in the same single or pair arrangement. In pair mode, bits leaving the top of J enter the bottom of K. Word 1374 octal therefore swaps J and K when W is 12.
- R9: Code 01 copies J to R and/or K to S. Code 02 copies R to J and/or S to K. Code 03 swaps J with R and/or K with S. In each case the select bits choose the pairs. Code 04 with only K selected (1204 octal) copies J to K.
- R10: A word whose top nibble is not 0010, or whose select bits are both zero, or any other low-six code (05–17, 26, 27, 36, 37, 22–25 and 32–35 with both selects, and 04 without K alone), leaves all registers and the overflow bit unchanged.
- R11: A shift or rotate with N = 0 leaves all registers unchanged.
- R12: With `exec_i` low, `load_en_i[0]` writes `load_data_i` into J and `load_en_i[1]` writes it into K on the clock edge. With `exec_i` high, the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute the word on `instr_i` this cycle |
| instr_i | input | 12 | Operate word |
| load_en_i | input | 2 | Parallel load enables: bit 0 J, bit 1 K |
| load_data_i | input | DATA_W | Parallel load value |
| done_o | output | 1 | Operation completed on the last edge |
| j_o | output | DATA_W | Main accumulator J |
| k_o | output | DATA_W | Main accumulator K |
| r_o | output | DATA_W | Sub-accumulator R |
| s_o | output | DATA_W | Sub-accumulator S |
| ovf_o | output | 1 | Overflow bit |

## Verification
The bench builds the unit with its default width of 12. At that width the 4-bit count field reaches 13 to 15, past the word size, so single-register rotates wrap and shifts clear the register. The 24-bit pair mode is exercised both within a half and across the J/K boundary. Loads biased toward 0x7FF, 0x800 and 0xFFF bring the signed overflow edges into reach, including negation of −2048 and negated results that return into range.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned INSTR_W = 12;
  localparam int unsigned CNT_W   = 4;

  typedef enum logic [2:0] {
    K_NONE,
    K_AND,
    K_ARITH,
    K_SHL,
    K_ROL,
    K_MOVE
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             pick_j;
    logic             pick_k;
    logic             neg;
    logic [2:0]       sub_op;
    logic [CNT_W-1:0] cnt;
  } dec_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [1:0] sel;
  logic [5:0] lo;
  logic       in_grp;

  always_comb begin
    sel    = instr_i[7:6];
    lo     = instr_i[5:0];
    in_grp = (instr_i[11:8] == 4'b0010) && (sel != 2'b00);

    dec_o        = '0;
    dec_o.kind   = K_NONE;
    dec_o.pick_j = sel[0];
    dec_o.pick_k = sel[1];
    dec_o.neg    = lo[3];
    dec_o.sub_op = lo[2:0];
    dec_o.cnt    = lo[3:0];

    if (in_grp) begin
      if (lo == 6'o00) begin
        dec_o.kind = K_AND;
      end else if (lo[5:3] == 3'b000) begin
        if (lo[2:0] <= 3'd3) dec_o.kind = K_MOVE;
        else if (lo[2:0] == 3'd4 && sel == 2'b10) dec_o.kind = K_MOVE;
      end else if (lo[5:4] == 2'b01) begin
        // pair destination only accepts J+K and J-K
        if (lo[2:0] <= 3'd5 && (sel != 2'b11 || lo[2:0] <= 3'd1))
          dec_o.kind = K_ARITH;
      end else if (lo[5:4] == 2'b10) begin
        dec_o.kind = K_SHL;
      end else if (lo[5:4] == 2'b11) begin
        dec_o.kind = K_ROL;
      end
    end
  end
endmodule

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] j_i,
  input  logic [W-1:0] k_i,
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  logic         use_k_i,
  input  logic [2:0]   code_i,
  input  logic         neg_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int unsigned XW = W + 2;

  logic [W-1:0]  d, x, y;
  logic [XW-1:0] xe, ye, sum, fin;

  always_comb begin
    d = use_k_i ? k_i : j_i;
    case (code_i[2:1])
      2'b00:   begin x = j_i; y = k_i; end
      2'b01:   begin x = r_i; y = d;   end
      default: begin x = s_i; y = d;   end
    endcase
    xe  = {{2{x[W-1]}}, x};
    ye  = {{2{y[W-1]}}, y};
    sum = code_i[0] ? (xe - ye) : (xe + ye);
    fin = neg_i ? (~sum + XW'(1)) : sum;
    res_o = fin[W-1:0];
    // exact result fits only if the two guard bits match the sign bit
    ovf_o = (fin[XW-1] != fin[W-1]) || (fin[W] != fin[W-1]);
  end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int unsigned W     = 12,
  parameter int unsigned CNT_W = 4
) (
  input  logic [W-1:0]     j_i,
  input  logic [W-1:0]     k_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rot_i,
  output logic [W-1:0]     j_one_o,
  output logic [W-1:0]     k_one_o,
  output logic [W-1:0]     pair_hi_o,
  output logic [W-1:0]     pair_lo_o
);
  localparam int unsigned STEPS = (1 << CNT_W) - 1;
  localparam int unsigned PW    = 2 * W;

  logic [W-1:0]  a, b;
  logic [PW-1:0] p;

  always_comb begin
    a = j_i;
    b = k_i;
    p = {j_i, k_i};
    for (int i = 0; i < STEPS; i++) begin
      if (i < int'(cnt_i)) begin
        a = {a[W-2:0],  rot_i & a[W-1]};
        b = {b[W-2:0],  rot_i & b[W-1]};
        p = {p[PW-2:0], rot_i & p[PW-1]};
      end
    end
    j_one_o   = a;
    k_one_o   = b;
    pair_hi_o = p[PW-1:W];
    pair_lo_o = p[W-1:0];
  end
endmodule

// File: rtl/acc_move.sv
module acc_move #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] j_i,
  input  logic [W-1:0] k_i,
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  logic [2:0]   op_i,
  input  logic         pick_j_i,
  input  logic         pick_k_i,
  output logic [W-1:0] j_o,
  output logic [W-1:0] k_o,
  output logic [W-1:0] r_o,
  output logic [W-1:0] s_o
);
  always_comb begin
    j_o = j_i;
    k_o = k_i;
    r_o = r_i;
    s_o = s_i;
    case (op_i)
      3'd1: begin
        if (pick_j_i) r_o = j_i;
        if (pick_k_i) s_o = k_i;
      end
      3'd2: begin
        if (pick_j_i) j_o = r_i;
        if (pick_k_i) k_o = s_i;
      end
      3'd3: begin
        if (pick_j_i) begin j_o = r_i; r_o = j_i; end
        if (pick_k_i) begin k_o = s_i; s_o = k_i; end
      end
      3'd4:    k_o = j_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_op_unit.sv
module acc_op_unit
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [11:0]       instr_i,
  input  logic [1:0]        load_en_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] j_o,
  output logic [DATA_W-1:0] k_o,
  output logic [DATA_W-1:0] r_o,
  output logic [DATA_W-1:0] s_o,
  output logic              ovf_o
);
  dec_t dec;

  logic [DATA_W-1:0] j_q, k_q, r_q, s_q;
  logic              ovf_q, done_q;
  logic [DATA_W-1:0] j_d, k_d, r_d, s_d;
  logic              ovf_d;

  logic [DATA_W-1:0] ar_res;
  logic              ar_ovf;
  logic [DATA_W-1:0] sh_j, sh_k, sh_hi, sh_lo;
  logic [DATA_W-1:0] mv_j, mv_k, mv_r, mv_s;

  acc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  acc_addsub #(.W(DATA_W)) u_addsub (
    .j_i     (j_q),
    .k_i     (k_q),
    .r_i     (r_q),
    .s_i     (s_q),
    .use_k_i (dec.pick_k & ~dec.pick_j),
    .code_i  (dec.sub_op),
    .neg_i   (dec.neg),
    .res_o   (ar_res),
    .ovf_o   (ar_ovf)
  );

  acc_shifter #(.W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .j_i       (j_q),
    .k_i       (k_q),
    .cnt_i     (dec.cnt),
    .rot_i     (dec.kind == K_ROL),
    .j_one_o   (sh_j),
    .k_one_o   (sh_k),
    .pair_hi_o (sh_hi),
    .pair_lo_o (sh_lo)
  );

  acc_move #(.W(DATA_W)) u_move (
    .j_i      (j_q),
    .k_i      (k_q),
    .r_i      (r_q),
    .s_i      (s_q),
    .op_i     (dec.sub_op),
    .pick_j_i (dec.pick_j),
    .pick_k_i (dec.pick_k),
    .j_o      (mv_j),
    .k_o      (mv_k),
    .r_o      (mv_r),
    .s_o      (mv_s)
  );

  always_comb begin
    j_d   = j_q;
    k_d   = k_q;
    r_d   = r_q;
    s_d   = s_q;
    ovf_d = ovf_q;
    if (exec_i) begin
      case (dec.kind)
        K_AND: begin
          if (dec.pick_j) j_d = j_q & k_q;
          if (dec.pick_k) k_d = j_q & k_q;
        end
        K_ARITH: begin
          if (dec.pick_j) j_d = ar_res;
          if (dec.pick_k) k_d = ar_res;
          ovf_d = ar_ovf;
        end
        K_SHL, K_ROL: begin
          if (dec.pick_j && dec.pick_k) begin
            j_d = sh_hi;
            k_d = sh_lo;
          end else if (dec.pick_j) begin
            j_d = sh_j;
          end else begin
            k_d = sh_k;
          end
        end
        K_MOVE: begin
          j_d = mv_j;
          k_d = mv_k;
          r_d = mv_r;
          s_d = mv_s;
        end
        default: ;
      endcase
    end else begin
      if (load_en_i[0]) j_d = load_data_i;
      if (load_en_i[1]) k_d = load_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      j_q    <= '0;
      k_q    <= '0;
      r_q    <= '0;
      s_q    <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      j_q    <= j_d;
      k_q    <= k_d;
      r_q    <= r_d;
      s_q    <= s_d;
      ovf_q  <= ovf_d;
      done_q <= exec_i;
    end
  end

  assign j_o    = j_q;
  assign k_o    = k_q;
  assign r_o    = r_q;
  assign s_o    = s_q;
  assign ovf_o  = ovf_q;
  assign done_o = done_q;
endmodule

// File: rtl/acc_op_unit_chk.sv
module acc_op_unit_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [11:0]       instr_i,
  input logic [1:0]        load_en_i,
  input logic              done_o,
  input logic [DATA_W-1:0] j_o,
  input logic [DATA_W-1:0] k_o,
  input logic [DATA_W-1:0] r_o,
  input logic [DATA_W-1:0] s_o,
  input logic              ovf_o
);
  p_done_after_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> done_o);

  p_done_needs_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(exec_i));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_i && load_en_i == 2'b00) |=>
      ($stable(j_o) && $stable(k_o) && $stable(r_o) && $stable(s_o) && $stable(ovf_o)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && instr_i[5:4] != 2'b01) |=> $stable(ovf_o));

  p_and_into_j_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && instr_i == 12'o1100) |=>
      (j_o == ($past(j_o) & $past(k_o)) && $stable(k_o)));

  p_swap_pairs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && instr_i == 12'o1303) |=>
      (j_o == $past(r_o) && r_o == $past(j_o) && k_o == $past(s_o) && s_o == $past(k_o)));

  p_foreign_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && instr_i[11:8] != 4'b0010) |=>
      ($stable(j_o) && $stable(k_o) && $stable(r_o) && $stable(s_o) && $stable(ovf_o)));

  p_load_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && instr_i[11:8] != 4'b0010 && load_en_i != 2'b00) |=>
      ($stable(j_o) && $stable(k_o)));
endmodule

bind acc_op_unit acc_op_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .exec_i    (exec_i),
  .instr_i   (instr_i),
  .load_en_i (load_en_i),
  .done_o    (done_o),
  .j_o       (j_o),
  .k_o       (k_o),
  .r_o       (r_o),
  .s_o       (s_o),
  .ovf_o     (ovf_o)
);

// File: tb/acc_op_unit_tb_top.sv
module acc_op_unit_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         exec = 1'b0;
  logic [11:0]  instr = '0;
  logic [1:0]   ld_en = '0;
  logic [W-1:0] ld_data = '0;
  logic         done_o, ovf_o;
  logic [W-1:0] j_o, k_o, r_o, s_o;

  acc_op_unit #(.DATA_W(W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .exec_i      (exec),
    .instr_i     (instr),
    .load_en_i   (ld_en),
    .load_data_i (ld_data),
    .done_o      (done_o),
    .j_o         (j_o),
    .k_o         (k_o),
    .r_o         (r_o),
    .s_o         (s_o),
    .ovf_o       (ovf_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] mj = '0, mk = '0, mr = '0, ms = '0;
  logic         mo = 1'b0;
  string        tag = "R1";

  function automatic longint sx(input logic [W-1:0] v);
    return v[W-1] ? (longint'(v) - (longint'(1) << W)) : longint'(v);
  endfunction

  task automatic check(input string t, input bit exp_done);
    n_chk++;
    if (j_o !== mj || k_o !== mk || r_o !== mr || s_o !== ms || ovf_o !== mo || done_o !== exp_done) begin
      n_bad++;
      $display("FAIL %s: got j=%h k=%h r=%h s=%h ov=%b done=%b exp j=%h k=%h r=%h s=%h ov=%b done=%b",
               t, j_o, k_o, r_o, s_o, ovf_o, done_o, mj, mk, mr, ms, mo, exp_done);
    end
  endtask

  // reference behaviour straight from the requirement text
  task automatic model(input logic [11:0] ins);
    logic [1:0]      sel;
    logic [5:0]      lo;
    logic [W-1:0]    d, v, tj, tk;
    logic [2*W-1:0]  p;
    longint          a;
    int              n;
    bit              rot;
    sel = ins[7:6];
    lo  = ins[5:0];
    tag = "R10";
    if (ins[11:8] != 4'b0010 || sel == 2'b00) return;
    if (lo == 6'o00) begin
      tag = "R6";
      v = mj & mk;
      if (sel[0]) mj = v;
      if (sel[1]) mk = v;
    end else if (lo >= 6'o01 && lo <= 6'o03) begin
      tag = "R9";
      tj = mj; tk = mk;
      if (lo == 6'o01) begin
        if (sel[0]) mr = tj;
        if (sel[1]) ms = tk;
      end else if (lo == 6'o02) begin
        if (sel[0]) mj = mr;
        if (sel[1]) mk = ms;
      end else begin
        if (sel[0]) begin mj = mr; mr = tj; end
        if (sel[1]) begin mk = ms; ms = tk; end
      end
    end else if (lo == 6'o04 && sel == 2'b10) begin
      tag = "R9";
      mk = mj;
    end else if (lo[5:4] == 2'b01 && lo[2:0] <= 3'd5 && (sel != 2'b11 || lo[2:0] <= 3'd1)) begin
      tag = lo[3] ? "R5" : "R4";
      d = (sel == 2'b10) ? mk : mj;
      case (lo[2:0])
        3'd0:    a = sx(mj) + sx(mk);
        3'd1:    a = sx(mj) - sx(mk);
        3'd2:    a = sx(mr) + sx(d);
        3'd3:    a = sx(mr) - sx(d);
        3'd4:    a = sx(ms) + sx(d);
        default: a = sx(ms) - sx(d);
      endcase
      if (lo[3]) a = -a;
      mo = (a < -(longint'(1) << (W - 1))) || (a > ((longint'(1) << (W - 1)) - 1));
      v = W'(a);
      if (sel[0]) mj = v;
      if (sel[1]) mk = v;
    end else if (lo[5]) begin
      rot = lo[4];
      n   = int'(lo[3:0]);
      tag = (n == 0) ? "R11" : (rot ? "R8" : "R7");
      if (sel == 2'b11) begin
        p = {mj, mk};
        for (int i = 0; i < n; i++) p = rot ? {p[2*W-2:0], p[2*W-1]} : {p[2*W-2:0], 1'b0};
        mj = p[2*W-1:W];
        mk = p[W-1:0];
      end else begin
        v = sel[0] ? mj : mk;
        for (int i = 0; i < n; i++) v = rot ? {v[W-2:0], v[W-1]} : {v[W-2:0], 1'b0};
        if (sel[0]) mj = v; else mk = v;
      end
    end
  endtask

  task automatic do_op(input logic [11:0] ins, input string force_tag);
    @(negedge clk);
    exec  = 1'b1;
    instr = ins;
    model(ins);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    exec = 1'b0;
    check(tag, 1'b1);
  endtask

  task automatic do_load(input logic [1:0] en, input logic [W-1:0] data);
    @(negedge clk);
    ld_en   = en;
    ld_data = data;
    if (en[0]) mj = data;
    if (en[1]) mk = data;
    @(negedge clk);
    ld_en = 2'b00;
    check("R12", 1'b0);
  endtask

  task automatic do_op_with_load(input logic [11:0] ins, input logic [W-1:0] data);
    @(negedge clk);
    exec    = 1'b1;
    instr   = ins;
    ld_en   = 2'b11;
    ld_data = data;
    model(ins);
    @(negedge clk);
    exec  = 1'b0;
    ld_en = 2'b00;
    check("R12", 1'b1);
  endtask

  task automatic do_idle();
    @(negedge clk);
    check("R2", 1'b0);
  endtask

  function automatic logic [W-1:0] pick_data();
    case ($urandom_range(0, 5))
      0:       return W'(12'h7ff);
      1:       return W'(12'h800);
      2:       return '1;
      3:       return '0;
      default: return W'($urandom);
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got run still active, exp finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    do_idle();

    // overflow on J+K at the positive edge
    do_load(2'b01, 12'h7ff);
    do_load(2'b10, 12'h001);
    do_op(12'o1120, "R3");
    do_op(12'o1100, "R3");
    do_op(12'o1450, "R10");
    // negation of the most negative value
    do_load(2'b01, 12'h800);
    do_load(2'b10, 12'h000);
    do_op(12'o1130, "R5");
    do_op(12'o1131, "R5");
    // fill R,S then exchange forms
    do_load(2'b01, 12'h5a3);
    do_load(2'b10, 12'h3c6);
    do_op(12'o1301, "R9");
    do_load(2'b11, 12'h0f0);
    do_op(12'o1303, "R9");
    do_op(12'o1204, "R9");
    do_op(12'o1123, "R4");
    do_op(12'o1235, "R5");
    // shift and rotate corners
    do_op(12'o1340, "R11");
    do_op(12'o1360, "R11");
    do_op(12'o1374, "R8");
    do_op(12'o1157, "R7");
    do_op(12'o1277, "R8");
    do_op(12'o1343, "R7");
    // unsupported words
    do_op(12'o1322, "R10");
    do_op(12'o1126, "R10");
    do_op(12'o1104, "R10");
    do_op(12'o1000, "R10");
    do_op(12'o5000, "R10");
    do_op_with_load(12'o5000, 12'habc);
    do_op_with_load(12'o1120, 12'h123);
    do_idle();

    for (int it = 0; it < 600; it++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) begin
        do_load(2'($urandom_range(1, 3)), pick_data());
      end else if (r == 2) begin
        do_idle();
      end else if (r == 3) begin
        do_op_with_load({4'b0010, 2'($urandom), 6'($urandom)}, pick_data());
      end else if ($urandom_range(0, 9) == 0) begin
        do_op(12'($urandom), "");
      end else begin
        do_op({4'b0010, 2'($urandom), 6'($urandom)}, "");
      end
    end

    finish_run();
  end
endmodule